// File: doc/BRIEF.md
# Retriggerable Gated One-Shot Pulser

This block is a clocked stand-in for a retriggerable monostable. Two gate inputs qualify the trigger. One is active-low and the other is active-high. A pulse starts only when the combined condition (low gate asserted low AND high gate asserted high) changes from false to true. Both gate inputs are first resynchronised through a two-flop chain, so slow or asynchronous edges are safe. The pulse length comes from a width input given in clock cycles instead of from external components. The output pair is a true output and its complement.

A new qualified edge during a pulse reloads the full width, so a steady stream of edges can hold the output asserted indefinitely. The kill input overrides everything. It drops the output in the same cycle without waiting for a clock edge. The edge detector keeps following the gate condition while kill is held, so releasing kill never creates a pulse.

Top module: `oneshot_pulser`

## Requirements
- R1: While `rst` is high, and after it falls until a new qualified edge, `pulse_o` is 0 and `pulse_n_o` is 1.
- R2: When `gate_n` falls while `gate_p` is high, `pulse_o` is still 0 after the second rising clock edge. It is 1 after the third, because two edges go to synchronisation and one to loading the timer.
- R3: When `gate_p` rises while `gate_n` is low, a pulse starts with the same three-edge latency as in R2.
- R4: An edge on one gate input while the other gate input is not asserted starts no pulse.
- R5: A pulse with no retrigger stays high for exactly `width_i` clock cycles.
- R6: A qualified edge during a pulse reloads the full width. With edges spaced no further apart than the width, the output never drops.
- R7: A qualified edge with `width_i` equal to 0 produces no pulse.
- R8: While `kill` is high, `pulse_o` is 0 in the same cycle, and qualified edges are ignored.
- R9: Releasing `kill` while the gate condition is true starts no pulse. A later false-to-true change of the condition starts one.
- R10: `pulse_n_o` is always the complement of `pulse_o`.
- R11: The width is captured when the trigger is taken. Changing `width_i` during a pulse does not change that pulse's length.
- R12: A gate condition that stays true starts no further pulse after the first one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| gate_n | input | 1 | Active-low trigger gate, asynchronous |
| gate_p | input | 1 | Active-high trigger gate, asynchronous |
| kill | input | 1 | Clear, active high; ends the pulse at once |
| width_i | input | CNT_W | Pulse width in clock cycles |
| pulse_o | output | 1 | Pulse output |
| pulse_n_o | output | 1 | Complement of `pulse_o` |

## Verification
The bench builds the block with `CNT_W` set to 8 and the default two-stage synchroniser. With these values the widths 0, 2, 5, 6 and 7 are all cheap to reach. The retrigger spacing can be set just below the width, so a held-high output is observed over many reloads. The kill and kill-release cases fall inside short windows where the exact latency through the synchroniser matters.

// File: rtl/oneshot_pkg.sv
`timescale 1ns/1ps
package oneshot_pkg;
    typedef struct packed {
        logic gate_n;
        logic gate_p;
    } gate_pair_t;

    localparam gate_pair_t GATE_IDLE = '{gate_n: 1'b1, gate_p: 1'b0};

    typedef struct packed {
        logic hist;
    } edge_st_t;
endpackage

// File: rtl/oneshot_sync.sv
`timescale 1ns/1ps
module oneshot_sync
    import oneshot_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  gate_pair_t raw_i,
    output gate_pair_t sync_o
);
    gate_pair_t stage_d [STAGES];
    gate_pair_t stage_q [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_comb begin
                    stage_d[gi] = rst ? GATE_IDLE : raw_i;
                end
            end else begin : g_rest
                always_comb begin
                    stage_d[gi] = rst ? GATE_IDLE : stage_q[gi-1];
                end
            end
            always_ff @(posedge clk) begin
                stage_q[gi] <= stage_d[gi];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/oneshot_edge.sv
`timescale 1ns/1ps
module oneshot_edge
    import oneshot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       kill,
    input  gate_pair_t sync_i,
    output logic       fire_o
);
    edge_st_t st_d, st_q;
    logic     cond;

    always_comb begin
        cond     = !sync_i.gate_n && sync_i.gate_p;
        fire_o   = cond && !st_q.hist && !kill && !rst;
        st_d     = st_q;
        // history tracks the condition always, including under kill
        st_d.hist = rst ? 1'b1 : cond;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/oneshot_timer.sv
`timescale 1ns/1ps
module oneshot_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             kill,
    input  logic             fire,
    input  logic [CNT_W-1:0] width_i,
    output logic             active_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } timer_st_t;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    timer_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst || kill) begin
            st_d.cnt = '0;
        end else if (fire) begin
            st_d.cnt = width_i;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign active_o = (st_q.cnt != '0);
endmodule

// File: rtl/oneshot_pulser.sv
`timescale 1ns/1ps
module oneshot_pulser
    import oneshot_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gate_n,
    input  logic             gate_p,
    input  logic             kill,
    input  logic [CNT_W-1:0] width_i,
    output logic             pulse_o,
    output logic             pulse_n_o
);
    gate_pair_t raw_gates;
    gate_pair_t sync_gates;
    logic       fire;
    logic       active;

    assign raw_gates = '{gate_n: gate_n, gate_p: gate_p};

    oneshot_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (raw_gates),
        .sync_o (sync_gates)
    );

    oneshot_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .kill   (kill),
        .sync_i (sync_gates),
        .fire_o (fire)
    );

    oneshot_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .kill     (kill),
        .fire     (fire),
        .width_i  (width_i),
        .active_o (active)
    );

    // kill masks the output without waiting for an edge
    assign pulse_o   = active && !kill;
    assign pulse_n_o = !pulse_o;
endmodule

// File: rtl/oneshot_pulser_chk.sv
`timescale 1ns/1ps
module oneshot_pulser_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             kill,
    input logic [CNT_W-1:0] width_i,
    input logic             pulse_o,
    input logic             pulse_n_o,
    input logic             fire
);
    // R1
    rst_quiet_chk: assert property (@(posedge clk) rst |=> !pulse_o);

    // R10
    qn_pair_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_n_o == !pulse_o);

    // R8
    kill_low_chk: assert property (@(posedge clk) disable iff (rst)
        kill |-> !pulse_o);

    // R2
    fire_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && width_i != '0) |=> (pulse_o || kill));

    // R7
    zero_width_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && width_i == '0) |=> !pulse_o);

    // R4
    no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!pulse_o && !fire) |=> !pulse_o);
endmodule

bind oneshot_pulser oneshot_pulser_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .kill      (kill),
    .width_i   (width_i),
    .pulse_o   (pulse_o),
    .pulse_n_o (pulse_n_o),
    .fire      (fire)
);

// File: tb/oneshot_pulser_tb.sv
`timescale 1ns/1ps
module oneshot_pulser_tb;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          gate_n = 1'b1;
    logic          gate_p = 1'b0;
    logic          kill = 1'b0;
    logic [CW-1:0] width_i = 8'd5;
    logic          pulse_o;
    logic          pulse_n_o;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    oneshot_pulser #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst), .gate_n(gate_n), .gate_p(gate_p),
        .kill(kill), .width_i(width_i), .pulse_o(pulse_o), .pulse_n_o(pulse_n_o)
    );

    // behavioural reference: sample history queues and a remaining-cycles integer
    bit gn_q[$];
    bit gp_q[$];
    bit m_prev_cond;
    int m_left;
    bit m_ready = 0;

    always @(posedge clk) begin
        bit c_now;
        if (rst) begin
            gn_q = '{1'b1, 1'b1};
            gp_q = '{1'b0, 1'b0};
            m_prev_cond = 1'b1;
            m_left = 0;
            m_ready = 1;
        end else if (m_ready) begin
            c_now = !gn_q[0] && gp_q[0];
            if (kill) m_left = 0;
            else if (c_now && !m_prev_cond) m_left = int'(width_i);
            else if (m_left > 0) m_left = m_left - 1;
            m_prev_cond = c_now;
            void'(gn_q.pop_front());
            void'(gp_q.pop_front());
            gn_q.push_back(gate_n);
            gp_q.push_back(gate_p);
        end
        #1;
        if (m_ready && !done) begin
            bit exp_q;
            exp_q = (m_left > 0) && !kill;
            checks++;
            if (pulse_o !== exp_q) begin
                errors++;
                $display("FAIL %s model: pulse_o=%b expected %b at %0t", cur_req, pulse_o, exp_q, $time);
            end
            checks++;
            if (pulse_n_o !== !exp_q) begin
                errors++;
                $display("FAIL R10 model: pulse_n_o=%b expected %b at %0t", pulse_n_o, !exp_q, $time);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit exp, input string req);
        checks++;
        if (pulse_o !== exp || pulse_n_o !== !exp) begin
            errors++;
            $display("FAIL %s: pulse_o=%b pulse_n_o=%b expected %b", req, pulse_o, pulse_n_o, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        finish_run();
    end

    initial begin
        // R1 reset state
        tick(3);
        chk(1'b0, "R1");
        rst = 1'b0;
        tick(2);
        gate_p = 1'b1;
        tick(4);
        chk(1'b0, "R1");

        // R2 falling low gate while high gate asserted, then R5 width
        cur_req = "R2";
        gate_n = 1'b0;
        tick(2); chk(1'b0, "R2");
        tick(1); chk(1'b1, "R2");
        cur_req = "R5";
        tick(4); chk(1'b1, "R5");
        tick(1); chk(1'b0, "R5");

        // R12 steady condition does not retrigger
        cur_req = "R12";
        tick(5); chk(1'b0, "R12");

        // R4 edge on one gate with the other idle
        cur_req = "R4";
        gate_p = 1'b0; tick(3);
        gate_n = 1'b1; tick(3);
        gate_n = 1'b0; tick(6); chk(1'b0, "R4");

        // R3 rising high gate while low gate asserted
        cur_req = "R3";
        gate_p = 1'b1;
        tick(2); chk(1'b0, "R3");
        tick(1); chk(1'b1, "R3");
        tick(5); chk(1'b0, "R3");

        // R6 retrigger every 4 cycles with width 5
        cur_req = "R6";
        for (int i = 0; i < 10; i++) begin
            gate_p = 1'b0; tick(2);
            gate_p = 1'b1; tick(2);
            if (i > 0) chk(1'b1, "R6");
        end
        tick(1);
        tick(4); chk(1'b1, "R6");
        tick(1); chk(1'b0, "R6");

        // R7 zero width
        cur_req = "R7";
        width_i = 8'd0;
        gate_p = 1'b0; tick(3);
        gate_p = 1'b1; tick(8); chk(1'b0, "R7");

        // R11 width captured at trigger
        cur_req = "R11";
        width_i = 8'd6;
        gate_p = 1'b0; tick(3);
        gate_p = 1'b1; tick(3); chk(1'b1, "R11");
        width_i = 8'd2;
        tick(5); chk(1'b1, "R11");
        tick(1); chk(1'b0, "R11");

        // R8 kill ends pulse at once and blocks triggers
        cur_req = "R8";
        width_i = 8'd7;
        gate_p = 1'b0; tick(3);
        gate_p = 1'b1; tick(4); chk(1'b1, "R8");
        kill = 1'b1;
        #1; chk(1'b0, "R8");
        gate_p = 1'b0; tick(3);
        gate_p = 1'b1; tick(5); chk(1'b0, "R8");

        // R9 release of kill with condition true
        cur_req = "R9";
        kill = 1'b0;
        tick(6); chk(1'b0, "R9");
        gate_p = 1'b0; tick(3);
        gate_p = 1'b1; tick(3); chk(1'b1, "R9");
        tick(10);

        finish_run();
    end
endmodule